// File: doc/BRIEF.md
# Response Start Tag Scanner

The scanner sits on the receive side of a byte-wide serial link and looks for framing tags in the incoming bytes. A controller starts it with a one-cycle `start` pulse and uses `mode` to pick one of two scans. In window mode it takes in a fixed window of bytes. It then picks the latest byte that can open a response header and checks that header. Older bytes that belong to an earlier packet's two-byte acknowledgement are passed over. In hunt mode it throws away bytes until a data start byte arrives and then tells the consumer that the payload follows. The hunt is bounded, so a link that stays silent cannot hang the scan.

Bytes come in over a valid/ready stream. A byte moves only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only while a scan runs. The source may drop `in_valid` in any cycle, and such bubbles do not change the result. When a scan ends, `in_ready` falls in the same cycle that `done` pulses, so the byte after a data start tag stays in the stream for the payload consumer. Verdict flags stay valid until the next accepted start. Payload storage and checksum checking are not part of this block.

Top module: `tag_scanner`

## Requirements
- R1: After reset, `in_ready`, `done`, `payload_go` and all four verdict flags (`ok`, `err_nohdr`, `err_rsp`, `err_tmo`) are low.
- R2: `start` is taken only while the block is idle (`in_ready` low). Taking it latches `mode` (0 = window, 1 = hunt), clears all verdict flags and raises `in_ready` in the next cycle. A `start` pulse during a scan is ignored.
- R3: In window mode exactly WIN_BYTES bytes are consumed (4 by default; byte 0 is the first received). `done` pulses in the cycle after the handshake of the last byte.
- R4: The window is searched from index WIN_BYTES-2 down to 0 for a byte whose upper nibble is 0xC. The highest such index is the selected header, so an earlier, stale header is skipped.
- R5: The selected header passes only if its lower nibble is 3 (last packet; 1 means first packet and 2 means inner packet) and the byte after it is 0x00. Then `ok` is set. Any other value sets `err_rsp`.
- R6: If no byte at indices 0 to WIN_BYTES-2 has upper nibble 0xC, `err_nohdr` is set. A 0xC byte at the final index does not count.
- R7: In hunt mode bytes are discarded until one with upper nibble 0xF is consumed. In the next cycle `done`, `ok` and `payload_go` are high and `in_ready` is low, so no further byte is taken.
- R8: A hunt consumes at most RETRY_LIMIT+1 bytes. If none of them is a data start byte, `done` and `err_tmo` are raised after the last one and the block returns to idle.
- R9: `done` and `payload_go` last a single cycle. With `done`, exactly one verdict flag is high. The flags hold their value until the next accepted `start`.
- R10: Bytes are consumed only on a valid/ready handshake. Cycles with `in_valid` low do not change the outcome, and bytes offered while idle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (taken while idle) |
| mode | input | 1 | 0 = window scan, 1 = data start hunt |
| in_valid | input | 1 | Incoming byte is valid |
| in_ready | output | 1 | Block accepts a byte (scan in progress) |
| in_data | input | 8 | Incoming byte |
| done | output | 1 | One-cycle end-of-scan pulse |
| ok | output | 1 | Scan succeeded |
| err_nohdr | output | 1 | No response header found in the window |
| err_rsp | output | 1 | Selected header has wrong type or status |
| err_tmo | output | 1 | Hunt exhausted its byte budget |
| payload_go | output | 1 | One-cycle pulse: payload follows |

## Verification
The bench keeps the default four-byte window, so the backward search, a stale header at index 0 behind a valid one at index 2, and a start nibble that appears only at the final index can all be checked directly. It sets RETRY_LIMIT to 6, which brings both sides of the hunt bound within a few cycles: a tag found on the last allowed byte, and a tag one byte too late that must end in a timeout. Streams with bubbles, a start pulse during a scan and bytes offered while idle cover the handshake rules.

// File: rtl/tag_scan_pkg.sv
`timescale 1ns/1ps
package tag_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_HUNT = 2'd2
  } scan_state_e;

  typedef struct packed {
    logic ok;
    logic nohdr;
    logic rsp;
    logic tmo;
  } verdict_t;

  localparam logic [3:0] HDR_NIB    = 4'hC;
  localparam logic [3:0] DATA_NIB   = 4'hF;
  localparam logic [3:0] TYPE_FIRST = 4'h1;
  localparam logic [3:0] TYPE_INNER = 4'h2;
  localparam logic [3:0] TYPE_LAST  = 4'h3;
  localparam logic [7:0] STAT_CLEAN = 8'h00;

endpackage

// File: rtl/tag_window_capture.sv
`timescale 1ns/1ps
module tag_window_capture #(
  parameter int unsigned WIN_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   push,
  input  logic [7:0]             din,
  output logic                   win_last,
  output logic [WIN_BYTES*8-1:0] win_next
);
  localparam int unsigned CW = (WIN_BYTES > 1) ? $clog2(WIN_BYTES) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(WIN_BYTES - 1);

  logic [7:0]    slot_q [WIN_BYTES];
  logic [CW-1:0] fill_q;

  assign win_last = push && (fill_q == LAST_SLOT);

  // The window as it stands once the byte being pushed is included.
  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = push && (fill_q == CW'(g));
    assign win_next[g*8 +: 8] = hit ? din : slot_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_q <= '0;
    else if (clear)      fill_q <= '0;
    else if (win_last)   fill_q <= '0;
    else if (push)       fill_q <= fill_q + 1'b1;
  end
endmodule

// File: rtl/tag_window_eval.sv
`timescale 1ns/1ps
module tag_window_eval
  import tag_scan_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 4
) (
  input  logic [WIN_BYTES*8-1:0] win_flat,
  output logic                   found,
  output logic                   hdr_good
);
  localparam int unsigned NSRCH = WIN_BYTES - 1;
  localparam int unsigned IW    = (NSRCH > 1) ? $clog2(NSRCH) : 1;

  logic [NSRCH-1:0] cand;
  logic [IW-1:0]    sel;
  logic [3:0]       sel_type;
  logic [7:0]       sel_stat;

  for (genvar g = 0; g < NSRCH; g++) begin : g_cand
    assign cand[g] = (win_flat[g*8+4 +: 4] == HDR_NIB);
  end

  // Ascending walk: the last candidate seen wins, giving the highest index.
  always_comb begin
    sel = '0;
    for (int i = 0; i < NSRCH; i++) begin
      if (cand[i]) sel = IW'(i);
    end
  end

  always_comb begin
    sel_type = '0;
    sel_stat = '0;
    for (int i = 0; i < NSRCH; i++) begin
      if (sel == IW'(i)) begin
        sel_type = win_flat[i*8 +: 4];
        sel_stat = win_flat[(i+1)*8 +: 8];
      end
    end
  end

  assign found    = |cand;
  assign hdr_good = found && (sel_type == TYPE_LAST) && (sel_stat == STAT_CLEAN);
endmodule

// File: rtl/tag_hunt_ctr.sv
`timescale 1ns/1ps
module tag_hunt_ctr #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic at_limit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] drop_q;

  assign at_limit = (drop_q == LIM_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 drop_q <= '0;
    else if (clear)             drop_q <= '0;
    else if (step && !at_limit) drop_q <= drop_q + 1'b1;
  end
endmodule

// File: rtl/tag_scanner.sv
`timescale 1ns/1ps
module tag_scanner
  import tag_scan_pkg::*;
#(
  parameter int unsigned WIN_BYTES   = 4,
  parameter int unsigned RETRY_LIMIT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       mode,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       done,
  output logic       ok,
  output logic       err_nohdr,
  output logic       err_rsp,
  output logic       err_tmo,
  output logic       payload_go
);
  scan_state_e state_q;
  verdict_t    verdict_q;
  logic        done_q, go_q;

  logic accept, take_start, win_push, win_last, hdr_found, hdr_good;
  logic hunt_acc, is_data_tag, hunt_step, hunt_limit;
  logic [WIN_BYTES*8-1:0] win_next;

  assign in_ready    = (state_q != ST_IDLE);
  assign accept      = in_valid && in_ready;
  assign take_start  = start && (state_q == ST_IDLE);
  assign win_push    = accept && (state_q == ST_WIN);
  assign hunt_acc    = accept && (state_q == ST_HUNT);
  assign is_data_tag = (in_data[7:4] == DATA_NIB);
  assign hunt_step   = hunt_acc && !is_data_tag;

  tag_window_capture #(.WIN_BYTES(WIN_BYTES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take_start),
    .push     (win_push),
    .din      (in_data),
    .win_last (win_last),
    .win_next (win_next)
  );

  tag_window_eval #(.WIN_BYTES(WIN_BYTES)) u_eval (
    .win_flat (win_next),
    .found    (hdr_found),
    .hdr_good (hdr_good)
  );

  tag_hunt_ctr #(.LIMIT(RETRY_LIMIT)) u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (take_start),
    .step     (hunt_step),
    .at_limit (hunt_limit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      verdict_q <= '0;
      done_q    <= 1'b0;
      go_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      go_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (take_start) begin
            verdict_q <= '0;
            state_q   <= mode ? ST_HUNT : ST_WIN;
          end
        end
        ST_WIN: begin
          if (win_last) begin
            verdict_q.ok    <= hdr_good;
            verdict_q.nohdr <= !hdr_found;
            verdict_q.rsp   <= hdr_found && !hdr_good;
            done_q          <= 1'b1;
            state_q         <= ST_IDLE;
          end
        end
        ST_HUNT: begin
          if (hunt_acc && is_data_tag) begin
            verdict_q.ok <= 1'b1;
            done_q       <= 1'b1;
            go_q         <= 1'b1;
            state_q      <= ST_IDLE;
          end else if (hunt_acc && hunt_limit) begin
            verdict_q.tmo <= 1'b1;
            done_q        <= 1'b1;
            state_q       <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign payload_go = go_q;
  assign ok         = verdict_q.ok;
  assign err_nohdr  = verdict_q.nohdr;
  assign err_rsp    = verdict_q.rsp;
  assign err_tmo    = verdict_q.tmo;
endmodule

// File: rtl/tag_scanner_chk.sv
`timescale 1ns/1ps
module tag_scanner_chk #(
  parameter int unsigned WIN_BYTES   = 4,
  parameter int unsigned RETRY_LIMIT = 100
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic mode,
  input logic in_valid,
  input logic in_ready,
  input logic done,
  input logic ok,
  input logic err_nohdr,
  input logic err_rsp,
  input logic err_tmo,
  input logic payload_go
);
  localparam int unsigned MAXB = (WIN_BYTES > RETRY_LIMIT + 1) ? WIN_BYTES : RETRY_LIMIT + 1;
  localparam int unsigned SW   = $clog2(MAXB + 2);

  logic [SW-1:0] seen_q;
  logic          mode_q;
  logic [3:0]    flags;

  assign flags = {ok, err_nohdr, err_rsp, err_tmo};

  // Bytes handed over since the last accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      mode_q <= 1'b0;
    end else if (start && !in_ready) begin
      seen_q <= '0;
      mode_q <= mode;
    end else if (in_valid && in_ready && seen_q != SW'(MAXB + 1)) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in_ready) |=> (in_ready && flags == 4'b0000));

  p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (seen_q == SW'(WIN_BYTES)));

  p_window_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mode_q) |-> (!err_tmo && !payload_go));

  p_hunt_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q) |-> (!err_nohdr && !err_rsp));

  p_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
    payload_go |-> (done && ok && mode_q && !in_ready));

  p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_tmo) |-> (seen_q == SW'(RETRY_LIMIT + 1)));

  p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (seen_q <= SW'(MAXB)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(flags) == 1));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !start) |=> $stable(flags));
endmodule

bind tag_scanner tag_scanner_chk #(
  .WIN_BYTES   (WIN_BYTES),
  .RETRY_LIMIT (RETRY_LIMIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mode       (mode),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .done       (done),
  .ok         (ok),
  .err_nohdr  (err_nohdr),
  .err_rsp    (err_rsp),
  .err_tmo    (err_tmo),
  .payload_go (payload_go)
);

// File: tb/tb_tag_scanner.sv
`timescale 1ns/1ps
module tb_tag_scanner;
  localparam int unsigned WIN = 4;
  localparam int unsigned RL  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0, in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, done, ok, err_nohdr, err_rsp, err_tmo, payload_go;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [4:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  tag_scanner #(.WIN_BYTES(WIN), .RETRY_LIMIT(RL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .done(done), .ok(ok), .err_nohdr(err_nohdr), .err_rsp(err_rsp),
    .err_tmo(err_tmo), .payload_go(payload_go)
  );

  function automatic logic [4:0] outs();
    return {ok, err_nohdr, err_rsp, err_tmo, payload_go};
  endfunction

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: compare each end-of-scan against the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected done", int'(outs()), 0);
        end else begin
          logic [4:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(outs() == e, t, int'(outs()), int'(e));
        end
      end
    end
  end

  // Driver: pushes the expected verdict, then streams bytes until the scan ends.
  task automatic run_case(input logic m, input logic [7:0] b[$], input logic [4:0] e,
                          input int exp_used, input string req, input bit gaps,
                          input bit poke);
    int used = 0;
    int idx = 0;
    bit bubble = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    start = 1'b1; mode = m;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready && outs() == 5'b0, "R2 start clears flags", int'(outs()), 0);
    while (in_ready && idx < b.size()) begin
      if (gaps && bubble) begin
        in_valid = 1'b0;
        bubble = 1'b0;
        @(negedge clk);
        continue;
      end
      bubble = 1'b1;
      in_valid = 1'b1;
      in_data = b[idx];
      if (poke && idx == 0) begin
        start = 1'b1; mode = ~m;
      end
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b0;
      used++;
      idx++;
    end
    chk(used == exp_used, {req, " bytes consumed"}, used, exp_used);
    chk(!in_ready, {req, " back to idle"}, int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk(outs() == {e[4:1], 1'b0}, "R9 flags hold", int'(outs()), int'({e[4:1], 1'b0}));
    chk(exp_q.size() == 0, {req, " done seen"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !done && outs() == 5'b0, "R1 reset state", int'({in_ready, done, outs()}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && outs() == 5'b0, "R1 after release", int'(outs()), 0);

    // R10: bytes offered while idle are ignored.
    in_valid = 1'b1; in_data = 8'hF3;
    repeat (3) @(negedge clk);
    chk(!done && !in_ready && outs() == 5'b0, "R10 idle bytes ignored", int'(outs()), 0);
    in_valid = 1'b0;

    // Window mode: verdict {ok,nohdr,rsp,tmo,go}
    run_case(1'b0, '{8'hC3, 8'h00, 8'h00, 8'h00, 8'h55}, 5'b10000, 4, "R3 window pass", 1'b0, 1'b0);
    run_case(1'b0, '{8'hC2, 8'h00, 8'hC3, 8'h00}, 5'b10000, 4, "R4 stale header skipped", 1'b0, 1'b0);
    run_case(1'b0, '{8'hC3, 8'h00, 8'hC1, 8'h00}, 5'b00100, 4, "R5 first-packet type", 1'b0, 1'b0);
    run_case(1'b0, '{8'hC3, 8'h00, 8'hC2, 8'h00}, 5'b00100, 4, "R5 inner-packet type", 1'b0, 1'b0);
    run_case(1'b0, '{8'h00, 8'hC3, 8'h07, 8'h00}, 5'b00100, 4, "R5 bad status", 1'b0, 1'b0);
    run_case(1'b0, '{8'h00, 8'h00, 8'h00, 8'hC3}, 5'b01000, 4, "R6 header at last index", 1'b0, 1'b0);
    run_case(1'b0, '{8'h11, 8'h22, 8'h33, 8'h44}, 5'b01000, 4, "R6 no header", 1'b0, 1'b0);
    run_case(1'b0, '{8'h00, 8'hC3, 8'h00, 8'hFF}, 5'b10000, 4, "R10 bubbles", 1'b1, 1'b0);
    run_case(1'b0, '{8'hC3, 8'h00, 8'h00, 8'h00}, 5'b10000, 4, "R2 start during scan", 1'b0, 1'b1);

    // Hunt mode, RETRY_LIMIT = 6
    run_case(1'b1, '{8'hF3, 8'hAA}, 5'b10001, 1, "R7 tag first byte", 1'b0, 1'b0);
    run_case(1'b1, '{8'h00, 8'hC3, 8'h0F, 8'hF0, 8'hAA}, 5'b10001, 4, "R7 tag after discards", 1'b1, 1'b0);
    run_case(1'b1, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0, 8'hAA},
             5'b10001, 7, "R8 tag on last allowed byte", 1'b0, 1'b0);
    run_case(1'b1, '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hF0},
             5'b00010, 7, "R8 timeout", 1'b0, 1'b0);
    run_case(1'b1, '{8'h00, 8'hC3, 8'hF1}, 5'b10001, 3, "R2 start during hunt", 1'b0, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule